// File: doc/BRIEF.md
# Dual-Address DMA Transfer Engine

This engine moves one data item per command between two addresses. It reads the item from the source into a 32-bit staging register, then writes it to the destination. The item may be 8, 16 or 32 bits wide, and the source and destination ports may each be narrower than the item. When a port is narrower, the engine splits that side of the move into 1, 2 or 4 bus cycles. The read side and the write side are split independently, so the two phases can use different numbers of cycles.

Each bus cycle is a request held until the slave acknowledges it. On a memory target, the address of each cycle moves up by the port width. On a peripheral target, every cycle goes to the same address and uses only the low byte lanes. A legal command ends with a one-cycle completion pulse that reports the byte count. A command whose port is wider than its item size is refused with an error pulse and causes no bus activity.

Top module: `dma_dual_xfer`

## Requirements
- R1: Size codes on `xfer_size`, `src_port` and `dst_port` use 2'b00 or 2'b01 = 32 bits, 2'b10 = 16 bits and 2'b11 = 8 bits. A start is refused when either port is wider than the item. A refused start gives `cfg_err` high for exactly the one cycle after it, starts no bus cycle and raises no `done`.
- R2: The read phase takes item/src_port bus cycles (`bus_we`=0). The write phase then takes item/dst_port bus cycles (`bus_we`=1). Each count is 1, 2 or 4, set independently for each side.
- R3: On a memory side (io flag 0), the address of bus cycle k is base + k × port bytes. On a peripheral side (io flag 1), every bus cycle of that phase uses the base address.
- R4: Each read cycle takes its data from the low port-width bits of `bus_rdata`, and the rest of `bus_rdata` is ignored. Successive read cycles fill the staging register from byte 0 upward.
- R5: Write cycle k drives staging bytes k×pw to k×pw+pw−1 (pw = destination port bytes) on the low lanes of `bus_wdata`, and all higher lanes are zero.
- R6: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values into the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the final write acknowledge. In that cycle `bytes_moved` equals the item size in bytes (4, 2 or 1). In every other cycle `bytes_moved` is 0, and `bus_req` is low while `done` is high.
- R8: `busy` is high from the cycle after an accepted start until the final write acknowledge. A start while `busy` is high is ignored.
- R9: A start given in the same cycle as `done` is accepted, and its first read cycle follows with no gap.
- R10: While reset is held, `bus_req`, `busy`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled while idle |
| xfer_size | input | 2 | Item size code |
| src_port | input | 2 | Source port width code |
| dst_port | input | 2 | Destination port width code |
| src_addr | input | AW | Source base address |
| dst_addr | input | AW | Destination base address |
| src_io | input | 1 | Source is a peripheral (no address stepping) |
| dst_io | input | 1 | Destination is a peripheral (no address stepping) |
| busy | output | 1 | Command in progress |
| cfg_err | output | 1 | Refused-command pulse |
| done | output | 1 | Completion pulse |
| bytes_moved | output | 3 | Byte count, valid with done |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | 32 | Write data, low lanes used |
| bus_rdata | input | 32 | Read data, low lanes used |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The completion of one command and the acceptance of the next can fall in the same cycle. In that cycle `done` is high and the engine is idle again, and it must take a fresh `start` without losing the byte count. The bench provokes this by watching for `done` and raising `start` in that very cycle. Its per-clock model then expects `done` and `bytes_moved` for the old command in that cycle, and the new command's first read request in the next one. A second overlap is a `start` arriving mid-command. The model treats it as having no effect, so any change to the bus sequence or to `busy` shows up as a mismatch.

// File: rtl/dma_dual_xfer.sv
module dma_dual_xfer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    xfer_size,
  input  logic [1:0]    src_port,
  input  logic [1:0]    dst_port,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          src_io,
  input  logic          dst_io,
  output logic          busy,
  output logic          cfg_err,
  output logic          done,
  output logic [2:0]    bytes_moved,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  function automatic logic [1:0] lg(input logic [1:0] c);
    return c[1] ? {1'b0, ~c[0]} : 2'd2;
  endfunction

  st_t          st;
  logic [1:0]   idx, lsz_q, lsp_q, ldp_q;
  logic [31:0]  hold;
  logic [AW-1:0] sa_q, da_q;
  logic         sio_q, dio_q, done_q, err_q;

  logic         legal, in_wr, io, last;
  logic [1:0]   cur_lg, span, idx_max;
  logic [4:0]   sh;
  logic [31:0]  mask;
  logic [AW-1:0] base;

  assign legal   = (lg(src_port) <= lg(xfer_size)) && (lg(dst_port) <= lg(xfer_size));
  assign in_wr   = (st == S_WR);
  assign cur_lg  = in_wr ? ldp_q : lsp_q;
  assign base    = in_wr ? da_q : sa_q;
  assign io      = in_wr ? dio_q : sio_q;
  assign span    = lsz_q - cur_lg;
  assign idx_max = (span == 2'd0) ? 2'd0 : (span == 2'd1) ? 2'd1 : 2'd3;
  assign last    = (idx == idx_max);
  assign sh      = {idx, 3'b000} << cur_lg;
  assign mask    = (cur_lg == 2'd0) ? 32'h0000_00FF :
                   (cur_lg == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  assign bus_req     = (st != S_IDLE);
  assign bus_we      = in_wr;
  assign busy        = bus_req;
  assign bus_addr    = io ? base : base + (AW'(idx) << cur_lg);
  assign bus_wdata   = in_wr ? ((hold >> sh) & mask) : 32'h0;
  assign done        = done_q;
  assign cfg_err     = err_q;
  assign bytes_moved = done_q ? 3'(3'd1 << lsz_q) : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      hold   <= '0;
      sa_q   <= '0;
      da_q   <= '0;
      lsz_q  <= '0;
      lsp_q  <= '0;
      ldp_q  <= '0;
      sio_q  <= 1'b0;
      dio_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (legal) begin
            st    <= S_RD;
            idx   <= '0;
            hold  <= '0;
            sa_q  <= src_addr;
            da_q  <= dst_addr;
            lsz_q <= lg(xfer_size);
            lsp_q <= lg(src_port);
            ldp_q <= lg(dst_port);
            sio_q <= src_io;
            dio_q <= dst_io;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_RD: if (bus_ack) begin
          hold <= hold | ((bus_rdata & mask) << sh);
          if (last) begin
            idx <= '0;
            st  <= S_WR;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_WR: if (bus_ack) begin
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module dma_dual_xfer_props #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          cfg_err,
  input logic          done,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_ack,
  input logic [1:0]    dst_lg
);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  assert_refuse_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !bus_req && !done);

  assert_err_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);

  assert_byte_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && dst_lg == 2'd0 |-> bus_wdata[31:8] == 24'h0);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);

endmodule

bind dma_dual_xfer dma_dual_xfer_props #(.AW(AW)) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cfg_err(cfg_err),
  .done(done), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .dst_lg(ldp_q)
);

// File: tb/dma_dual_xfer_test.sv
module dma_dual_xfer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] xfer_size = 2'b00, src_port = 2'b00, dst_port = 2'b00;
  logic [31:0] src_addr = '0, dst_addr = '0, bus_addr, bus_wdata, bus_rdata = '0;
  logic src_io = 1'b0, dst_io = 1'b0, bus_ack = 1'b0;
  logic busy, cfg_err, done, bus_req, bus_we;
  logic [2:0] bytes_moved;

  dma_dual_xfer #(.AW(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_size(xfer_size),
    .src_port(src_port), .dst_port(dst_port), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_io(src_io), .dst_io(dst_io), .busy(busy), .cfg_err(cfg_err), .done(done),
    .bytes_moved(bytes_moved), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic        last;
    logic [2:0]  nbytes;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cyc = 0, waitc = 0;
  bit ack_q = 0, exp_err = 0, done_seen = 0;

  function automatic int blen(input logic [1:0] c);
    return c[1] ? (c[0] ? 1 : 2) : 4;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    bit ed;
    logic [2:0] eb;
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
    if (!rst_n) begin
      chk(!bus_req && !busy && !done && !cfg_err, "R10 reset outputs",
          {bus_req, busy, done, cfg_err}, 4'b0);
      bus_ack = 1'b0;
      ack_q = 0;
    end else begin
      ed = 0;
      eb = 3'd0;
      if (ack_q) begin
        it = q.pop_front();
        if (it.last) begin
          ed = 1;
          eb = it.nbytes;
        end
      end
      done_seen = ed;
      chk(done == ed, "R7 done pulse", done, ed);
      chk(bytes_moved == eb, "R7 bytes_moved", bytes_moved, eb);
      chk(busy == (q.size() != 0), "R8 busy", busy, q.size() != 0);
      chk(cfg_err == exp_err, "R1 cfg_err", cfg_err, exp_err);
      exp_err = 0;
      if (q.size() != 0) begin
        it = q[0];
        chk(bus_req == 1'b1, "R2 request present", bus_req, 1);
        chk(bus_we == it.we, "R2 phase order", bus_we, it.we);
        chk(bus_addr == it.addr, "R3 address", bus_addr, it.addr);
        if (it.we)
          chk(bus_wdata == it.data, "R4/R5 write data", bus_wdata, it.data);
        for (int b = 0; b < 4; b++) bus_rdata[8*b +: 8] = mem_byte(it.addr + 32'(b));
        if (waitc == 0) begin
          bus_ack = 1'b1;
          waitc = $urandom_range(0, 2);
        end else begin
          bus_ack = 1'b0;
          waitc--;
        end
      end else begin
        chk(bus_req == 1'b0, "R2 no request when idle", bus_req, 0);
        bus_ack = 1'b0;
      end
      ack_q = bus_ack;
    end
  end

  task automatic issue(input logic [1:0] sz, input logic [1:0] sp, input logic [1:0] dp,
                       input logic [31:0] sa, input logic [31:0] da, input bit sio, input bit dio,
                       input bit now);
    int nb, ps, pd;
    logic [7:0] h [4];
    item_t it;
    if (!now) begin
      @(negedge clk);
      #1;
    end
    xfer_size = sz; src_port = sp; dst_port = dp;
    src_addr = sa; dst_addr = da; src_io = sio; dst_io = dio;
    start = 1'b1;
    nb = blen(sz); ps = blen(sp); pd = blen(dp);
    if (ps > nb || pd > nb) begin
      exp_err = 1;
    end else begin
      for (int j = 0; j < nb / ps; j++) begin
        it = '0;
        it.addr = sio ? sa : sa + 32'(j * ps);
        q.push_back(it);
        for (int b = 0; b < ps; b++) h[j*ps + b] = mem_byte(it.addr + 32'(b));
      end
      for (int j = 0; j < nb / pd; j++) begin
        it = '0;
        it.we = 1'b1;
        it.addr = dio ? da : da + 32'(j * pd);
        for (int b = 0; b < pd; b++) it.data[8*b +: 8] = h[j*pd + b];
        it.last = (j == nb / pd - 1);
        it.nbytes = 3'(nb);
        q.push_back(it);
      end
    end
    @(negedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    do begin
      @(negedge clk);
      #1;
    end while (!done_seen);
  endtask

  task automatic xfer(input logic [1:0] sz, input logic [1:0] sp, input logic [1:0] dp,
                      input logic [31:0] sa, input logic [31:0] da, input bit sio, input bit dio);
    issue(sz, sp, dp, sa, da, sio, dio, 0);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R2 R3 R4 R5 memory to memory, varied split ratios
    xfer(2'b00, 2'b00, 2'b00, 32'h0000_1000, 32'h0000_2000, 0, 0);
    xfer(2'b00, 2'b11, 2'b11, 32'h0000_1103, 32'h0000_2207, 0, 0);
    xfer(2'b01, 2'b10, 2'b11, 32'h0000_3010, 32'h0000_4020, 0, 0);
    xfer(2'b10, 2'b11, 2'b10, 32'h0000_5031, 32'h0000_6042, 0, 0);
    xfer(2'b11, 2'b11, 2'b11, 32'h0000_70A9, 32'h0000_80B1, 0, 0);
    xfer(2'b00, 2'b11, 2'b10, 32'hFFFF_FFFE, 32'h0000_0100, 0, 0);
    // R3 peripheral sides keep the address
    xfer(2'b10, 2'b11, 2'b11, 32'h0000_9005, 32'h0000_A00B, 1, 1);
    xfer(2'b00, 2'b10, 2'b11, 32'h0000_B012, 32'h0000_C033, 1, 0);
    xfer(2'b00, 2'b11, 2'b10, 32'h0000_D044, 32'h0000_E055, 0, 1);
    // R1 refused combinations
    issue(2'b10, 2'b00, 2'b11, 32'h10, 32'h20, 0, 0, 0);
    @(negedge clk);
    issue(2'b11, 2'b11, 2'b10, 32'h30, 32'h40, 0, 0, 0);
    @(negedge clk);
    issue(2'b10, 2'b10, 2'b01, 32'h50, 32'h60, 0, 0, 0);
    repeat (2) @(negedge clk);
    // R8 start while busy has no effect
    issue(2'b00, 2'b11, 2'b11, 32'h0000_F100, 32'h0000_F200, 0, 0, 0);
    #1;
    xfer_size = 2'b11; src_port = 2'b11; dst_port = 2'b11;
    src_addr = 32'hDEAD_0000; dst_addr = 32'hBEEF_0000; src_io = 1; dst_io = 1;
    start = 1'b1;
    repeat (3) @(negedge clk);
    #1 start = 1'b0;
    wait_done();
    // R9 new start in the done cycle
    issue(2'b00, 2'b10, 2'b10, 32'h0000_0400, 32'h0000_0500, 0, 0, 0);
    wait_done();
    issue(2'b10, 2'b11, 2'b11, 32'h0000_0600, 32'h0000_0700, 0, 1, 1);
    wait_done();
    issue(2'b11, 2'b11, 2'b11, 32'h0000_0801, 32'h0000_0902, 1, 0, 1);
    wait_done();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule